// File: doc/BRIEF.md
# Ramp-Counter PWM Generator with Complementary Outputs and Dead Time

This block produces a pair of complementary switch-drive signals from a single clock-driven ramp counter. The counter runs in one of three shapes: counting up and wrapping, counting down and wrapping, or climbing to the period value and falling back. Its period input sets the switching frequency. A compare input sets the duty cycle, and a higher compare value gives a wider `pwmA` pulse. A controller scales its current-loop output by the period in counts and presents the product as the compare value.

Before the outputs leave the block, each one has its own rising-edge delay, so the high-side and low-side switches never conduct together. The period, compare value, ramp shape and both delays may change at any time. They are captured only at the period boundary, so the running cycle is never disturbed. An enable input low forces both drive signals low in the same cycle.

Top module: `pwmDeadTimeGen`

## Requirements
- R1: `modeSel` selects the ramp shape: 0 counts up 0..P-1 and wraps to 0, 1 counts down P-1..0 and wraps to P-1, 2 counts 0 up to P and then back down to 1 before returning to 0, and 3 behaves as 0. In up mode, `rampCount` rises by exactly one every cycle except at the wrap.
- R2: With active period P, one switching period lasts P cycles in modes 0, 1 and 3, and 2P cycles in mode 2. `rampCount` never exceeds P-1, or P in mode 2. A period input of 0 is treated as 1.
- R3: With compare C, the undelayed `pwmA` decision is high for min(C,P) cycles per period in modes 0, 1 and 3, and for 2·min(C,P) cycles in mode 2. The pulse sits at the start of the ramp in up mode, at its end in down mode, and is centred on count 0 in mode 2.
- R4: C = 0 keeps `pwmA` low for whole periods. C ≥ P keeps `pwmA` high for whole periods, with no low cycle.
- R5: The undelayed `pwmB` decision is the inverse of the `pwmA` decision. `pwmA` and `pwmB` are never high in the same cycle.
- R6: Each output follows its decision one clock later. A rising edge is held back by a further `deadRiseA` or `deadRiseB` cycles, so each high pulse is shortened by its delay and a pulse no longer than its delay vanishes. A new delay written while running takes effect.
- R7: Period, compare, mode and both delays are sampled only at the period boundary. The counter then restarts at 0, or at P-1 in down mode. A change made in the middle of a period leaves that period's length and pulse unchanged.
- R8: `outEn` low drives both `pwmA` and `pwmB` low in the same cycle.
- R9: While `rstN` is low, `rampCount`, `pwmA` and `pwmB` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| outEn | input | 1 | Output enable; low forces both outputs low |
| modeSel | input | 2 | Ramp shape: 0 up, 1 down, 2 up-down, 3 as up |
| periodIn | input | CNT_W | Requested period in counts (shadowed) |
| cmpIn | input | CNT_W | Requested compare value (shadowed) |
| deadRiseA | input | DT_W | Rising-edge delay of `pwmA` in cycles (shadowed) |
| deadRiseB | input | DT_W | Rising-edge delay of `pwmB` in cycles (shadowed) |
| pwmA | output | 1 | Primary switch drive |
| pwmB | output | 1 | Complementary switch drive |
| rampCount | output | CNT_W | Current ramp counter value |

## Verification
The assertions take for granted only that inputs are stable around each rising clock edge. Any value on any input is legal, including period 0, mode 3, and compare values above the period. The bench changes inputs just after a falling edge and samples outputs at falling edges, so every input is settled long before the next rising edge. It writes new settings in the middle of a period on purpose, so the shadow capture is exercised rather than avoided. Before measuring, it waits several full periods so that the new settings have been loaded.

// File: rtl/pwmGenPkg.sv
package pwmGenPkg;

  typedef enum logic [1:0] {
    RAMP_UP     = 2'd0,
    RAMP_DOWN   = 2'd1,
    RAMP_UPDOWN = 2'd2,
    RAMP_UP_ALT = 2'd3
  } rampMode_e;

  // Strobes from the ramp control to the datapath
  typedef struct packed {
    logic load;      // period boundary: capture shadows, restart ramp
    logic step;      // move the counter by one
    logic stepDown;  // direction of the step (1 = decrement)
    logic turnDown;  // leave the rising leg of the up-down ramp
  } rampStrobe_t;

  function automatic rampMode_e normMode(input logic [1:0] m);
    return (m == 2'd3) ? RAMP_UP : rampMode_e'(m);
  endfunction

endpackage

// File: rtl/pwmRampCtrl.sv
module pwmRampCtrl
  import pwmGenPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] rampCount,
  input  logic [CNT_W-1:0] activePer,
  input  rampMode_e        activeMode,
  input  logic             upLeg,
  output rampStrobe_t      strobes
);

  localparam int EXT_W = CNT_W + 1;

  logic lastUp;

  // next count would reach the period value
  assign lastUp = ({1'b0, rampCount} + EXT_W'(1)) >= {1'b0, activePer};

  always_comb begin
    strobes = '0;
    case (activeMode)
      RAMP_DOWN: begin
        if (rampCount == '0) begin
          strobes.load = 1'b1;
        end else begin
          strobes.step     = 1'b1;
          strobes.stepDown = 1'b1;
        end
      end
      RAMP_UPDOWN: begin
        if (upLeg) begin
          strobes.step     = 1'b1;
          strobes.turnDown = lastUp;
        end else if (rampCount <= CNT_W'(1)) begin
          strobes.load = 1'b1;
        end else begin
          strobes.step     = 1'b1;
          strobes.stepDown = 1'b1;
        end
      end
      default: begin
        if (lastUp) strobes.load = 1'b1;
        else        strobes.step = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pwmRampDatapath.sv
module pwmRampDatapath
  import pwmGenPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4,
  parameter int CH_N  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rampStrobe_t               strobes,
  input  logic [1:0]                modeIn,
  input  logic [CNT_W-1:0]          periodIn,
  input  logic [CNT_W-1:0]          cmpIn,
  input  logic [CH_N-1:0][DT_W-1:0] dtIn,
  output logic [CNT_W-1:0]          rampCount,
  output logic [CNT_W-1:0]          activePer,
  output logic [CNT_W-1:0]          activeCmp,
  output rampMode_e                 activeMode,
  output logic                      upLeg,
  output logic [CH_N-1:0][DT_W-1:0] activeDt,
  output logic [CH_N-1:0]           rawPwm
);

  logic [CNT_W-1:0] perNew;
  rampMode_e        modeNew;
  logic             aHigh;

  assign perNew  = (periodIn == '0) ? CNT_W'(1) : periodIn;
  assign modeNew = normMode(modeIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampCount  <= '0;
      activePer  <= CNT_W'(1);
      activeCmp  <= '0;
      activeMode <= RAMP_UP;
      upLeg      <= 1'b1;
      activeDt   <= '0;
    end else if (strobes.load) begin
      activePer  <= perNew;
      activeCmp  <= cmpIn;
      activeMode <= modeNew;
      activeDt   <= dtIn;
      upLeg      <= 1'b1;
      rampCount  <= (modeNew == RAMP_DOWN) ? perNew - CNT_W'(1) : '0;
    end else if (strobes.step) begin
      rampCount <= strobes.stepDown ? rampCount - CNT_W'(1) : rampCount + CNT_W'(1);
      if (strobes.turnDown) upLeg <= 1'b0;
    end
  end

  // Falling leg compares inclusively so the up-down pulse is 2*C wide
  assign aHigh  = upLeg ? (rampCount < activeCmp) : (rampCount <= activeCmp);
  assign rawPwm = {~aHigh, aHigh};

endmodule

// File: rtl/pwmDeadBand.sv
module pwmDeadBand #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rawIn,
  input  logic [DT_W-1:0] delay,
  output logic            pwmOut
);

  logic [DT_W-1:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highRun <= '0;
      pwmOut  <= 1'b0;
    end else begin
      pwmOut <= rawIn && (highRun >= delay);
      if (!rawIn)               highRun <= '0;
      else if (highRun != '1)   highRun <= highRun + DT_W'(1);
    end
  end

endmodule

// File: rtl/pwmDeadTimeGen.sv
module pwmDeadTimeGen
  import pwmGenPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outEn,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic [DT_W-1:0]  deadRiseA,
  input  logic [DT_W-1:0]  deadRiseB,
  output logic             pwmA,
  output logic             pwmB,
  output logic [CNT_W-1:0] rampCount
);

  localparam int CH_N = 2;

  rampStrobe_t               strobes;
  logic [CNT_W-1:0]          activePer;
  logic [CNT_W-1:0]          activeCmp;
  rampMode_e                 activeMode;
  logic                      upLeg;
  logic [CH_N-1:0][DT_W-1:0] dtIn;
  logic [CH_N-1:0][DT_W-1:0] activeDt;
  logic [CH_N-1:0]           rawPwm;
  logic [CH_N-1:0]           bandOut;
  logic                      rawA;

  assign dtIn = {deadRiseB, deadRiseA};
  assign rawA = rawPwm[0];

  pwmRampCtrl #(.CNT_W(CNT_W)) ctrl (
    .rampCount (rampCount),
    .activePer (activePer),
    .activeMode(activeMode),
    .upLeg     (upLeg),
    .strobes   (strobes)
  );

  pwmRampDatapath #(.CNT_W(CNT_W), .DT_W(DT_W), .CH_N(CH_N)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .modeIn    (modeSel),
    .periodIn  (periodIn),
    .cmpIn     (cmpIn),
    .dtIn      (dtIn),
    .rampCount (rampCount),
    .activePer (activePer),
    .activeCmp (activeCmp),
    .activeMode(activeMode),
    .upLeg     (upLeg),
    .activeDt  (activeDt),
    .rawPwm    (rawPwm)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : gBand
    pwmDeadBand #(.DT_W(DT_W)) band (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawPwm[ch]),
      .delay (activeDt[ch]),
      .pwmOut(bandOut[ch])
    );
  end

  assign pwmA = bandOut[0] & outEn;
  assign pwmB = bandOut[1] & outEn;

endmodule

// File: rtl/pwmDeadTimeGenChecker.sv
module pwmDeadTimeGenChecker
  import pwmGenPkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmA,
  input logic             pwmB,
  input logic [CNT_W-1:0] rampCount,
  input logic [CNT_W-1:0] activePer,
  input logic [CNT_W-1:0] activeCmp,
  input rampMode_e        activeMode
);

  assert_up_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == RAMP_UP && $past(activeMode) == RAMP_UP && rampCount != '0)
      |-> rampCount == $past(rampCount) + CNT_W'(1));

  assert_ramp_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == RAMP_UPDOWN) ? (rampCount <= activePer) : (rampCount < activePer));

  assert_zero_cmp_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(activeCmp) == '0) |-> !pwmA);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmA && pwmB));

  assert_shadow_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeCmp) |->
      ((activeMode == RAMP_DOWN && rampCount == activePer - CNT_W'(1)) ||
       (activeMode != RAMP_DOWN && rampCount == '0)));

endmodule

bind pwmDeadTimeGen pwmDeadTimeGenChecker #(.CNT_W(CNT_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwmA      (pwmA),
  .pwmB      (pwmB),
  .rampCount (rampCount),
  .activePer (activePer),
  .activeCmp (activeCmp),
  .activeMode(activeMode)
);

// File: tb/pwmDeadTimeGen_test.sv
`timescale 1ns/1ps
module pwmDeadTimeGen_test;

  localparam int CNT_W = 8;
  localparam int DT_W  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             outEn = 1'b1;
  logic [1:0]       modeSel = 2'd0;
  logic [CNT_W-1:0] periodIn = '0;
  logic [CNT_W-1:0] cmpIn = '0;
  logic [DT_W-1:0]  deadRiseA = '0;
  logic [DT_W-1:0]  deadRiseB = '0;
  logic             pwmA;
  logic             pwmB;
  logic [CNT_W-1:0] rampCount;

  int checks = 0;
  int fails = 0;
  int overlaps = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwmDeadTimeGen #(.CNT_W(CNT_W), .DT_W(DT_W)) uut (
    .clk(clk), .rstN(rstN), .outEn(outEn), .modeSel(modeSel),
    .periodIn(periodIn), .cmpIn(cmpIn), .deadRiseA(deadRiseA),
    .deadRiseB(deadRiseB), .pwmA(pwmA), .pwmB(pwmB), .rampCount(rampCount)
  );

  always @(negedge clk) if (rstN && pwmA && pwmB) overlaps++;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pcOf(input int mode, input int p);
    int pe = (p == 0) ? 1 : p;
    return (mode == 2) ? 2 * pe : pe;
  endfunction

  function automatic int hOf(input int mode, input int p, input int c);
    int pe = (p == 0) ? 1 : p;
    return ((c < pe) ? c : pe) * ((mode == 2) ? 2 : 1);
  endfunction

  function automatic int expA(input int mode, input int p, input int c, input int d);
    int pc = pcOf(mode, p);
    int h  = hOf(mode, p, c);
    if (h >= pc) return pc;
    return (h > d) ? h - d : 0;
  endfunction

  function automatic int expB(input int mode, input int p, input int c, input int d);
    int pc = pcOf(mode, p);
    int l  = pc - hOf(mode, p, c);
    if (l >= pc) return pc;
    return (l > d) ? l - d : 0;
  endfunction

  task automatic configure(input int mode, input int p, input int c, input int da, input int db);
    @(negedge clk);
    modeSel   = 2'(mode);
    periodIn  = CNT_W'(p);
    cmpIn     = CNT_W'(c);
    deadRiseA = DT_W'(da);
    deadRiseB = DT_W'(db);
    repeat (6 * (p + 1) + 10) @(negedge clk);
  endtask

  task automatic waitCount(input int v);
    int guard = 0;
    @(negedge clk);
    while (rampCount != CNT_W'(v) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic measurePeriod(input string req, input int expPc, input int expMax);
    int n = 0;
    int mx = 0;
    waitCount(0);
    do begin
      @(negedge clk);
      n++;
      if (int'(rampCount) > mx) mx = int'(rampCount);
    end while (rampCount != '0 && n < 1000);
    checkEq(req, "period cycles", n, expPc);
    checkEq(req, "highest count", mx, expMax);
  endtask

  task automatic measureDuty(input string req, input int pc, input int ea, input int eb);
    int a = 0;
    int b = 0;
    for (int i = 0; i < pc; i++) begin
      @(negedge clk);
      if (pwmA) a++;
      if (pwmB) b++;
    end
    checkEq(req, "pwmA high cycles", a, ea);
    checkEq(req, "pwmB high cycles", b, eb);
  endtask

  task automatic runCase(input string req, input int mode, input int p, input int c,
                         input int da, input int db);
    int pe = (p == 0) ? 1 : p;
    configure(mode, p, c, da, db);
    measurePeriod(req, pcOf(mode, p), (mode == 2) ? pe : pe - 1);
    measureDuty(req, pcOf(mode, p), expA(mode, p, c, da), expB(mode, p, c, db));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkEq("R9", "count in reset", int'(rampCount), 0);
    checkEq("R9", "pwmA in reset", int'(pwmA), 0);
    checkEq("R9", "pwmB in reset", int'(pwmB), 0);
  endtask

  task automatic testModes();
    runCase("R1", 0, 10, 4, 2, 1);
    runCase("R1", 1, 12, 5, 0, 3);
    runCase("R2", 2, 8, 3, 1, 2);
    runCase("R1", 3, 7, 2, 0, 0);
  endtask

  task automatic testPosition();
    // down ramp: pulse at the end of the ramp, seen one cycle later
    configure(1, 12, 5, 0, 0);
    waitCount(11);
    checkEq("R3", "down pwmA just after wrap", int'(pwmA), 1);
    waitCount(10);
    checkEq("R3", "down pwmA early in ramp", int'(pwmA), 0);
    // up-down: centred on count 0
    configure(2, 8, 3, 0, 0);
    waitCount(0);
    checkEq("R3", "up-down pwmA at count 0", int'(pwmA), 1);
    waitCount(8);
    checkEq("R3", "up-down pwmA at peak", int'(pwmA), 0);
  endtask

  task automatic testLimits();
    runCase("R4", 0, 10, 0, 3, 3);
    runCase("R4", 0, 10, 10, 3, 3);
    runCase("R4", 0, 10, 15, 2, 2);
    runCase("R4", 2, 8, 8, 1, 1);
    runCase("R2", 0, 0, 1, 0, 0);
  endtask

  task automatic testDeadChange();
    configure(0, 10, 5, 0, 0);
    measureDuty("R6", 10, 5, 5);
    @(negedge clk);
    deadRiseA = DT_W'(3);
    repeat (40) @(negedge clk);
    measureDuty("R6", 10, 2, 5);
    @(negedge clk);
    deadRiseB = DT_W'(6);
    repeat (40) @(negedge clk);
    measureDuty("R6", 10, 2, 0);
  endtask

  task automatic testShadow();
    int mx = 0;
    int guard = 0;
    configure(0, 10, 5, 0, 0);
    waitCount(2);
    cmpIn    = CNT_W'(8);
    periodIn = CNT_W'(6);
    waitCount(7);
    checkEq("R7", "pwmA keeps old compare", int'(pwmA), 0);
    mx = 7;
    do begin
      @(negedge clk);
      guard++;
      if (int'(rampCount) > mx) mx = int'(rampCount);
    end while (rampCount != '0 && guard < 100);
    checkEq("R7", "old period runs to end", mx, 9);
    measurePeriod("R7", 6, 5);
    measureDuty("R7", 6, 6, 0);
  endtask

  task automatic testEnable();
    int hi = 0;
    configure(0, 10, 5, 0, 0);
    waitCount(2);
    checkEq("R8", "pwmA high before disable", int'(pwmA), 1);
    outEn = 1'b0;
    #0.5;
    checkEq("R8", "pwmA same cycle", int'(pwmA), 0);
    checkEq("R8", "pwmB same cycle", int'(pwmB), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmA || pwmB) hi++;
    end
    checkEq("R8", "high cycles while disabled", hi, 0);
    outEn = 1'b1;
    repeat (20) @(negedge clk);
    measureDuty("R8", 10, 5, 5);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testModes();
    testPosition();
    testLimits();
    testDeadChange();
    testShadow();
    testEnable();
    checkEq("R5", "cycles with both outputs high", overlaps, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule